// File: doc/BRIEF.md
# Outbound Address Window Translator

This block turns a CPU-side address inside a fixed outbound region into a 64-bit bus-side address. The region is cut into a bank of equal slots, and the slot size is a power of two in megabytes. The address bits above the in-slot offset pick the slot, so no base/limit compare is needed. Each slot holds a 64-bit replacement offset. Bit 0 of its low word enables that slot, and the remaining bits form the target base. A global enable gates every translation.

Software programs the slots through a small 32-bit register port. Each register can be written and read in one cycle. A typical setup gives a 1:1 map of a contiguous range: the slots are filled in order, and each target is one slot size above the previous one. On the translation side, the block takes an address with a valid strobe. One cycle later it returns the translated address, a hit flag and the index of the slot.

Top module: `oat_xlate`

## Requirements
- R1: After reset the control register (offset 0x004) reads 0, the size register (offset 0x030) reads 3, every slot register reads 0, and out_valid is low.
- R2: Registers read back what was written, with these limits. The control register keeps only bit 1, which is the global enable. The size register keeps bits [2:0]. The low word of slot n is at 0x200+8n and the high word is at 0x204+8n, and both keep all 32 bits. An unmapped offset reads 0.
- R3: While the global enable is 0, no address produces a hit.
- R4: The slot index is (in_addr - REGION_BASE) >> (20 + size). A hit requires the global enable, an index below NUM_WIN and bit 0 of that slot's low word set. out_win then carries the index.
- R5: On a hit, out_addr = {high word, low word with bit 0 cleared} + (in_addr - REGION_BASE) mod 2^(20+size).
- R6: An address in a slot whose enable bit is 0 gives out_hit = 0, out_addr = 0 and out_win = 0.
- R7: An address below REGION_BASE, or one at or above REGION_BASE + NUM_WIN slot sizes, gives no hit.
- R8: Changing the size register changes the slot granularity: size 0 gives 1 MB slots and size 1 gives 2 MB slots.
- R9: out_valid equals in_valid of the previous cycle. out_hit is never high while out_valid is low.
- R10: When a register write and a translation fall in the same cycle, the translation uses the register contents from before the write. The next translation uses the new contents.
- R11: Adding the in-slot offset carries from bit 31 into bit 32 of the 64-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr |
| in_valid | input | 1 | Input address valid |
| in_addr | input | IN_AW | CPU-side address |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_hit | output | 1 | Address landed in an enabled slot |
| out_addr | output | 64 | Translated bus address, 0 without a hit |
| out_win | output | IDXW | Index of the hit slot, 0 without a hit |

## Verification
A slot or size register can be written in the same clock in which an address that depends on it is being translated. The bench provokes this in two ways: it rewrites a slot's offset while an address in that slot is presented, and it disables a slot while an address hits it. The reference model computes each expected result from its register copy before it applies that edge's write. So the result must reflect the old contents in that cycle and the new contents in the following one. Every cycle is compared against the model, including gaps in in_valid and addresses on both sides of the region edges.

// File: rtl/oat_pkg.sv
package oat_pkg;
  localparam int CSR_AW   = 12;
  localparam int SZW      = 3;
  localparam int MB_SHIFT = 20;
  localparam logic [CSR_AW-1:0] ADDR_CTRL  = 12'h004;
  localparam logic [CSR_AW-1:0] ADDR_SIZE  = 12'h030;
  localparam logic [CSR_AW-1:0] ADDR_SLOT0 = 12'h200;
  localparam int CTRL_EN_BIT  = 1;
  localparam logic [SZW-1:0] SIZE_RESET = 3'd3;
endpackage

// File: rtl/oat_regfile.sv
module oat_regfile
  import oat_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CSR_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              glob_en,
  output logic [SZW-1:0]    size_q,
  output logic [31:0]       lo_q [NUM_WIN],
  output logic [31:0]       hi_q [NUM_WIN]
);
  logic           en_d;
  logic [SZW-1:0] size_d;
  logic           ctrl_we, size_we;

  assign ctrl_we = reg_wr && (reg_addr == ADDR_CTRL);
  assign size_we = reg_wr && (reg_addr == ADDR_SIZE);

  always_comb begin
    en_d   = glob_en;
    size_d = size_q;
    if (ctrl_we) en_d   = reg_wdata[CTRL_EN_BIT];
    if (size_we) size_d = reg_wdata[SZW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en <= 1'b0;
      size_q  <= SIZE_RESET;
    end else begin
      if (ctrl_we) glob_en <= en_d;
      if (size_we) size_q  <= size_d;
    end
  end

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_slot
    localparam logic [CSR_AW-1:0] LO_A = ADDR_SLOT0 + CSR_AW'(8 * n);
    localparam logic [CSR_AW-1:0] HI_A = LO_A + CSR_AW'(4);
    logic        lo_we, hi_we;
    logic [31:0] lo_d, hi_d;

    assign lo_we = reg_wr && (reg_addr == LO_A);
    assign hi_we = reg_wr && (reg_addr == HI_A);

    always_comb begin
      lo_d = lo_q[n];
      hi_d = hi_q[n];
      if (lo_we) lo_d = reg_wdata;
      if (hi_we) hi_d = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[n] <= '0;
        hi_q[n] <= '0;
      end else begin
        if (lo_we) lo_q[n] <= lo_d;
        if (hi_we) hi_q[n] <= hi_d;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CTRL) reg_rdata[CTRL_EN_BIT] = glob_en;
    if (reg_addr == ADDR_SIZE) reg_rdata[SZW-1:0] = size_q;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (reg_addr == ADDR_SLOT0 + CSR_AW'(8 * i))     reg_rdata = lo_q[i];
      if (reg_addr == ADDR_SLOT0 + CSR_AW'(8 * i + 4)) reg_rdata = hi_q[i];
    end
  end

  a_r2_size_lands: assert property (@(posedge clk) disable iff (!rst_n)
    size_we |=> size_q == $past(reg_wdata[SZW-1:0]));
  a_r2_ctrl_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> glob_en == $past(reg_wdata[CTRL_EN_BIT]));
endmodule

// File: rtl/oat_decode.sv
module oat_decode
  import oat_pkg::*;
#(
  parameter int              NUM_WIN     = 8,
  parameter int              IN_AW       = 32,
  parameter logic [IN_AW-1:0] REGION_BASE = '0,
  localparam int             IDXW        = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [IN_AW-1:0] in_addr,
  input  logic [SZW-1:0]   size,
  output logic             in_range,
  output logic [IDXW-1:0]  idx,
  output logic [IN_AW-1:0] ofs
);
  logic [IN_AW:0]   rel_ext;
  logic [IN_AW-1:0] rel, idx_full, low_mask;
  logic [7:0]       shamt;

  always_comb begin
    rel_ext  = {1'b0, in_addr} - {1'b0, REGION_BASE};
    rel      = rel_ext[IN_AW-1:0];
    shamt    = 8'(MB_SHIFT) + 8'(size);
    idx_full = rel >> shamt;
    low_mask = ~({IN_AW{1'b1}} << shamt);
    ofs      = rel & low_mask;
    idx      = idx_full[IDXW-1:0];
    in_range = !rel_ext[IN_AW] && (idx_full < IN_AW'(NUM_WIN));
  end
endmodule

// File: rtl/oat_result.sv
module oat_result #(
  parameter int NUM_WIN = 8,
  parameter int IN_AW   = 32,
  localparam int IDXW   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             glob_en,
  input  logic             in_range,
  input  logic [IDXW-1:0]  idx,
  input  logic [IN_AW-1:0] ofs,
  input  logic [31:0]      lo_q [NUM_WIN],
  input  logic [31:0]      hi_q [NUM_WIN],
  output logic             out_valid,
  output logic             out_hit,
  output logic [63:0]      out_addr,
  output logic [IDXW-1:0]  out_win
);
  logic            slot_en, hit_d;
  logic [63:0]     base64, addr_d;
  logic [IDXW-1:0] win_d;

  always_comb begin
    slot_en = lo_q[idx][0];
    base64  = {hi_q[idx], lo_q[idx][31:1], 1'b0};
    hit_d   = in_valid && glob_en && in_range && slot_en;
    addr_d  = hit_d ? (base64 + 64'(ofs)) : 64'd0;
    win_d   = hit_d ? idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_addr  <= '0;
      out_win   <= '0;
    end else begin
      out_valid <= in_valid;
      out_hit   <= hit_d;
      out_addr  <= addr_d;
      out_win   <= win_d;
    end
  end
endmodule

// File: rtl/oat_xlate.sv
module oat_xlate
  import oat_pkg::*;
#(
  parameter int               NUM_WIN     = 8,
  parameter int               IN_AW       = 32,
  parameter logic [IN_AW-1:0] REGION_BASE = 32'h2000_0000,
  localparam int              IDXW        = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CSR_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              in_valid,
  input  logic [IN_AW-1:0]  in_addr,
  output logic              out_valid,
  output logic              out_hit,
  output logic [63:0]       out_addr,
  output logic [IDXW-1:0]   out_win
);
  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             glob_en, in_range;
  logic [SZW-1:0]   size_q;
  logic [31:0]      lo_q [NUM_WIN];
  logic [31:0]      hi_q [NUM_WIN];
  logic [IDXW-1:0]  dec_idx;
  logic [IN_AW-1:0] dec_ofs;
  logic [NUM_WIN-1:0] slot_en_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  oat_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .glob_en(glob_en),
    .size_q(size_q), .lo_q(lo_q), .hi_q(hi_q)
  );

  oat_decode #(.NUM_WIN(NUM_WIN), .IN_AW(IN_AW), .REGION_BASE(REGION_BASE)) u_dec (
    .in_addr(in_addr), .size(size_q), .in_range(in_range), .idx(dec_idx), .ofs(dec_ofs)
  );

  oat_result #(.NUM_WIN(NUM_WIN), .IN_AW(IN_AW)) u_res (
    .clk(clk), .rst_n(rst_int_n), .in_valid(in_valid), .glob_en(glob_en),
    .in_range(in_range), .idx(dec_idx), .ofs(dec_ofs), .lo_q(lo_q), .hi_q(hi_q),
    .out_valid(out_valid), .out_hit(out_hit), .out_addr(out_addr), .out_win(out_win)
  );

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_env
    assign slot_en_vec[n] = lo_q[n][0];
  end

  a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);
  a_r9_valid_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid);
  a_r9_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_hit |-> out_valid);
  a_r3_global_off: assert property (@(posedge clk) disable iff (!rst_int_n)
    !glob_en |=> !out_hit);
  a_r6_slot_off: assert property (@(posedge clk) disable iff (!rst_int_n)
    !slot_en_vec[dec_idx] |=> !out_hit);
endmodule

// File: tb/tb_oat_xlate.sv
module tb_oat_xlate;
  localparam int NW = 8;
  localparam logic [31:0] BASE = 32'h2000_0000;
  localparam int IDXW = $clog2(NW);

  logic        clk, rst_n, reg_wr, in_valid;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, in_addr;
  logic        out_valid, out_hit;
  logic [63:0] out_addr;
  logic [IDXW-1:0] out_win;

  oat_xlate #(.NUM_WIN(NW), .IN_AW(32), .REGION_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_addr(in_addr), .out_valid(out_valid), .out_hit(out_hit),
    .out_addr(out_addr), .out_win(out_win)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit chk_on = 0;
  string tag = "R1", exp_tag = "R1";

  logic [31:0] m_lo [NW];
  logic [31:0] m_hi [NW];
  logic [2:0]  m_size = 3'd3;
  bit          m_en = 0;
  bit          e_v = 0, e_h = 0;
  logic [63:0] e_a = 0;
  int          e_w = 0;

  initial clk = 0;
  always #10 clk = ~clk;

  initial for (int i = 0; i < NW; i++) begin m_lo[i] = 0; m_hi[i] = 0; end

  always @(posedge clk) begin
    logic [63:0] rel, msk;
    int sh, ix;
    bit hit;
    cycles++;
    exp_tag = tag;
    e_v = in_valid; e_h = 0; e_a = 0; e_w = 0;
    if (in_valid) begin
      rel = {32'd0, in_addr} - {32'd0, BASE};
      sh  = 20 + int'(m_size);
      ix  = int'(rel >> sh);
      hit = m_en && (in_addr >= BASE) && (ix < NW);
      if (hit) hit = m_lo[ix][0];
      if (hit) begin
        msk = (64'd1 << sh) - 64'd1;
        e_h = 1; e_w = ix;
        e_a = {m_hi[ix], m_lo[ix] & 32'hFFFF_FFFE} + (rel & msk);
      end
    end
    if (reg_wr) begin
      if (reg_addr == 12'h004) m_en = reg_wdata[1];
      if (reg_addr == 12'h030) m_size = reg_wdata[2:0];
      for (int i = 0; i < NW; i++) begin
        if (reg_addr == 12'(12'h200 + 8 * i)) m_lo[i] = reg_wdata;
        if (reg_addr == 12'(12'h204 + 8 * i)) m_hi[i] = reg_wdata;
      end
    end
  end

  always @(negedge clk) if (chk_on) begin
    checks++;
    if (out_valid !== e_v || out_hit !== e_h || out_addr !== e_a || int'(out_win) != e_w) begin
      errors++;
      $display("FAIL %s: valid/hit/addr/win actual %0b/%0b/%h/%0d expected %0b/%0b/%h/%0d",
               exp_tag, out_valid, out_hit, out_addr, out_win, e_v, e_h, e_a, e_w);
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) if (cycles > 100000) begin
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string t);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: read %h actual %h expected %h", t, a, reg_rdata, exp);
    end
  endtask

  task automatic xl(input logic [31:0] a);
    in_valid = 1; in_addr = a;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [31:0] MB8 = 32'h0080_0000;

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; in_valid = 0; in_addr = 0;
    idle(3);
    rst_n = 1;
    idle(4);
    chk_on = 1;
    // R1 reset state
    tag = "R1";
    rd(12'h004, 32'd0, "R1"); rd(12'h030, 32'd3, "R1");
    rd(12'h200, 32'd0, "R1"); rd(12'h23C, 32'd0, "R1");
    idle(1);
    // R2 readback and masking
    tag = "R2";
    wr(12'h210, 32'hABCD_1235); rd(12'h210, 32'hABCD_1235, "R2");
    wr(12'h214, 32'h0000_00C7); rd(12'h214, 32'h0000_00C7, "R2");
    wr(12'h030, 32'hFFFF_FFFF); rd(12'h030, 32'd7, "R2");
    wr(12'h004, 32'hFFFF_FFFD); rd(12'h004, 32'd0, "R2");
    wr(12'h004, 32'h0000_0002); rd(12'h004, 32'd2, "R2");
    rd(12'h100, 32'd0, "R2");
    wr(12'h004, 32'd0); wr(12'h030, 32'd3);
    // 1:1 map, slots enabled, global off
    for (int i = 0; i < NW; i++) begin
      wr(12'(12'h200 + 8 * i), (BASE + MB8 * i) | 32'd1);
      wr(12'(12'h204 + 8 * i), 32'd0);
    end
    tag = "R3";
    xl(BASE + 32'h10); xl(BASE + MB8 * 2 + 32'h44);
    idle(1);
    wr(12'h004, 32'd2);
    // R4/R5 identity mapping across slots
    tag = "R4";
    xl(BASE); xl(BASE + MB8 * 3 + 32'h1234); xl(BASE + MB8 * 8 - 32'd4);
    tag = "R5";
    wr(12'h220, 32'h8000_0001); wr(12'h224, 32'h0000_0012);
    xl(BASE + MB8 * 4 + 32'h0007_FF00); xl(BASE + MB8 * 4);
    // R11 carry into upper word
    tag = "R11";
    wr(12'h228, 32'hFFF0_0001); wr(12'h22C, 32'h0000_0001);
    xl(BASE + MB8 * 5 + 32'h0030_0000);
    // R6 disabled slot
    tag = "R6";
    wr(12'h218, BASE + MB8 * 3);
    xl(BASE + MB8 * 3 + 32'h20); xl(BASE + MB8 * 2 + 32'h20);
    // R7 region edges
    tag = "R7";
    xl(BASE - 32'd4); xl(BASE + MB8 * 8); xl(32'hFFFF_FFF0); xl(32'd0);
    // R9 valid gaps
    tag = "R9";
    idle(2); xl(BASE + 32'h8); idle(1); xl(BASE + 32'h8); xl(BASE + MB8); idle(2);
    // R10 write during translation
    tag = "R10";
    reg_wr = 1; reg_addr = 12'h208; reg_wdata = 32'h4000_0001;
    in_valid = 1; in_addr = BASE + MB8 + 32'h100;
    @(negedge clk);
    reg_wr = 0;
    in_addr = BASE + MB8 + 32'h100;
    @(negedge clk);
    reg_wr = 1; reg_addr = 12'h200; reg_wdata = BASE;
    in_addr = BASE + 32'h40;
    @(negedge clk);
    reg_wr = 0;
    @(negedge clk);
    in_valid = 0;
    reg_wr = 1; reg_addr = 12'h004; reg_wdata = 0; in_valid = 1; in_addr = BASE + MB8 * 2;
    @(negedge clk);
    reg_wr = 0;
    @(negedge clk);
    in_valid = 0;
    wr(12'h004, 32'd2);
    // R8 granularity
    tag = "R8";
    wr(12'h030, 32'd0);
    xl(BASE + 32'h0010_0004); xl(BASE + 32'h0070_0010); xl(BASE + 32'h0080_0000);
    wr(12'h030, 32'd1);
    xl(BASE + 32'h0020_0008); xl(BASE + 32'h00F0_0000); xl(BASE + 32'h0100_0000);
    reg_wr = 1; reg_addr = 12'h030; reg_wdata = 32'd3; in_valid = 1; in_addr = BASE + 32'h0030_0000;
    @(negedge clk);
    reg_wr = 0;
    @(negedge clk);
    in_valid = 0;
    idle(3);
    finish_run();
  end
endmodule